// File: doc/BRIEF.md
# Fetch/Execute Clock-Enable Sequencer

This block produces the per-cycle capture enables for a small non-pipelined processor. The processor runs every register from one free-running fast clock, and this block never gates that clock. Each instruction takes three base cycles: a single fetch cycle, then two execute cycles. The execute logic therefore gets a two-cycle path, and its registers capture only on the second execute cycle. All phase control reaches the datapath as synchronous enables, so no decoded logic ever drives a clock pin.

The sequencer is a three-state machine with the states FETCH (code 0), EXEC1 (code 1) and EXEC2 (code 2). It has these transitions:
- FETCH to EXEC1 when not stalled.
- EXEC1 to EXEC2 when not stalled.
- EXEC2 to FETCH when not stalled.
- Every state to itself while stall is high.
- Every state to FETCH under reset.

The unused code 3 falls back to FETCH. The block has three enables: a fetch-register enable, an execute-register enable, and a memory enable. The memory enable is active on both capture slots, so the memory sees the cadence 101 per instruction and holds its outputs on the idle slot. A stall input lets slow memory or peripherals insert wait states.

Top module: `fx_enable_seq`

## Requirements
- R1: A synchronous active-high reset puts the phase to FETCH (code 0) at the next clock edge. All enables and the done pulse are low in any cycle where reset is high.
- R2: With stall low, the phase output steps through FETCH (0), EXEC1 (1), EXEC2 (2) and back to FETCH, one step per clock.
- R3: The fetch enable is high exactly in the cycles where the phase is FETCH and stall is low.
- R4: The execute enable is high exactly in the cycles where the phase is EXEC2 and stall is low. The fetch and execute enables are never high together.
- R5: While stall is high, the phase holds its value at the next edge, and the fetch, execute and memory enables are all low.
- R6: The memory enable is high exactly when the fetch or execute enable is high. It is low in EXEC1, which gives the pattern 1,0,1 per unstalled instruction.
- R7: The instruction-done output is a one-cycle pulse that is high in the same cycle as the execute enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running base clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Wait request; holds the current phase |
| fetch_en_o | output | 1 | Capture enable for fetch-stage registers |
| exec_en_o | output | 1 | Capture enable for execute-stage registers |
| mem_en_o | output | 1 | Clock enable for both memory ports |
| phase_o | output | 2 | Current phase code: 0 FETCH, 1 EXEC1, 2 EXEC2 |
| instr_done_o | output | 1 | One-cycle pulse at the execute capture |

## Verification
The bench first runs a long stretch with stall held low. This shows the base three-slot cadence and the 1,0,1 memory pattern. Single-cycle stalls are then placed in FETCH, in EXEC1 and in EXEC2 in turn. These separate a correct hold-in-place from designs that skip a phase or still fire an enable while waiting. A multi-cycle stall and back-to-back stalls show that the hold lasts as long as the request. A reset asserted partway through an instruction shows that the phase restarts at FETCH rather than carrying on.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;
    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC1 = 2'd1,
        PH_EXEC2 = 2'd2
    } phase_e;
endpackage

// File: rtl/fx_phase_fsm.sv
module fx_phase_fsm
    import fx_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    output phase_e phase_q
);
    phase_e phase_d;

    // Next-phase selection; stall freezes the sequence in place.
    always_comb begin
        phase_d = phase_q;
        if (!stall) begin
            unique case (phase_q)
                PH_FETCH: phase_d = PH_EXEC1;
                PH_EXEC1: phase_d = PH_EXEC2;
                PH_EXEC2: phase_d = PH_FETCH;
                default:  phase_d = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/fx_enable_decode.sv
module fx_enable_decode
    import fx_seq_pkg::*;
(
    input  logic   rst,
    input  logic   stall,
    input  phase_e phase,
    output logic   fetch_en,
    output logic   exec_en,
    output logic   mem_en,
    output logic   done
);
    logic active;

    assign active = !rst && !stall;

    // One process for all outputs; only capture slots raise enables.
    always_comb begin
        fetch_en = 1'b0;
        exec_en  = 1'b0;
        unique case (phase)
            PH_FETCH: fetch_en = active;
            PH_EXEC1: ;
            PH_EXEC2: exec_en  = active;
            default:  ;
        endcase
        mem_en = fetch_en | exec_en;
        done   = exec_en;
    end
endmodule

// File: rtl/fx_enable_seq.sv
module fx_enable_seq
    import fx_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    output logic               fetch_en_o,
    output logic               exec_en_o,
    output logic               mem_en_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               instr_done_o
);
    phase_e phase_q;

    fx_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .phase_q (phase_q)
    );

    fx_enable_decode u_dec (
        .rst      (rst),
        .stall    (stall),
        .phase    (phase_q),
        .fetch_en (fetch_en_o),
        .exec_en  (exec_en_o),
        .mem_en   (mem_en_o),
        .done     (instr_done_o)
    );

    assign phase_o = phase_q;
endmodule

// File: rtl/fx_enable_seq_chk.sv
module fx_enable_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic       fetch_en_o,
    input logic       exec_en_o,
    input logic       mem_en_o,
    input logic [1:0] phase_o,
    input logic       instr_done_o
);
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd0 && !stall) |=> phase_o == 2'd1);

    p_exec2_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd2 && !stall) |=> phase_o == 2'd0);

    p_fetch_only_r3: assert property (@(posedge clk) disable iff (rst)
        fetch_en_o |-> phase_o == 2'd0);

    p_excl_en_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_en_o, exec_en_o}));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(phase_o));

    p_stall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        stall |-> !mem_en_o);

    p_exec1_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |-> !mem_en_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        instr_done_o |=> !instr_done_o);
endmodule

bind fx_enable_seq fx_enable_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .fetch_en_o   (fetch_en_o),
    .exec_en_o    (exec_en_o),
    .mem_en_o     (mem_en_o),
    .phase_o      (phase_o),
    .instr_done_o (instr_done_o)
);

// File: tb/fx_enable_seq_test.sv
module fx_enable_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       stall;
    logic       fetch_en_o, exec_en_o, mem_en_o, instr_done_o;
    logic [1:0] phase_o;

    int checks = 0;
    int errors = 0;
    int model_phase = 0;
    bit just_reset = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fx_enable_seq uut (
        .clk          (clk),
        .rst          (rst),
        .stall        (stall),
        .fetch_en_o   (fetch_en_o),
        .exec_en_o    (exec_en_o),
        .mem_en_o     (mem_en_o),
        .phase_o      (phase_o),
        .instr_done_o (instr_done_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, compare against the behavioural model, then advance it.
    task automatic step(bit r, bit s);
        int ef, ee;
        @(negedge clk);
        rst   = r;
        stall = s;
        #1;
        ef = (!r && !s && model_phase == 0) ? 1 : 0;
        ee = (!r && !s && model_phase == 2) ? 1 : 0;
        if (r) begin
            chk("R1 enables low in reset", int'(fetch_en_o | exec_en_o | mem_en_o | instr_done_o), 0);
        end else begin
            if (just_reset) chk("R1 phase after reset", int'(phase_o), 0);
            chk("R2 phase", int'(phase_o), model_phase);
            chk("R3 fetch_en", int'(fetch_en_o), ef);
            chk("R4 exec_en", int'(exec_en_o), ee);
            chk("R4 exclusive", int'(fetch_en_o & exec_en_o), 0);
            if (s) chk("R5 mem_en low on stall", int'(mem_en_o), 0);
            chk("R6 mem_en", int'(mem_en_o), (ef | ee));
            chk("R7 done", int'(instr_done_o), ee);
        end
        just_reset = r;
        if (r) model_phase = 0;
        else if (!s) model_phase = (model_phase + 1) % 3;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        stall = 1'b0;
        step(1, 0);
        step(1, 0);
        // Free run: base cadence.
        for (int i = 0; i < 12; i++) step(0, 0);
        // Single stalls in FETCH, EXEC1, EXEC2 (model phase is 0 here).
        step(0, 1); step(0, 0);
        step(0, 1); step(0, 0);
        step(0, 1); step(0, 0);
        for (int i = 0; i < 3; i++) step(0, 0);
        // Long stall and back-to-back stalls.
        for (int i = 0; i < 5; i++) step(0, 1);
        for (int i = 0; i < 4; i++) step(0, 0);
        for (int i = 0; i < 8; i++) step(0, (i % 2) == 0);
        // Reset partway through an instruction.
        step(0, 0);
        step(1, 0);
        for (int i = 0; i < 7; i++) step(0, 0);
        // Reset while stalled.
        step(0, 1);
        step(1, 1);
        for (int i = 0; i < 6; i++) step(0, (i == 3));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule